// File: doc/BRIEF.md
# Serial Control Register Target

This block is a two-wire serial bus target that holds seven 8-bit control registers for an audio gain stage. It runs entirely on the system clock: both bus lines are oversampled through two-flop synchronizers, and bus edges, START, repeated START and STOP are found on the synchronized levels. The target answers at 7-bit address 0x58 and drives SDA low to acknowledge. The first byte after the write address loads a register pointer. Each following byte is written to the pointed register, and the pointer then advances by one.

A read starts with a pointer write. A repeated START with the read address follows. The target then returns consecutive registers until the master answers NACK. Three status flags are set by hardware event inputs and are cleared only by writing zero to them. Holding the shutdown input low puts every register back to its reset value. Only addresses 1 to 7 are backed by storage. Every other address ignores writes and reads back zero.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After START, the target acknowledges the address byte 0xB0 (write) or 0xB1 (read) by holding SDA low through the ninth SCL clock. Any other address byte gets no acknowledge, and SDA stays released until the next START.
- R2: START (SDA falling while SCL is high) restarts byte framing at any point. STOP (SDA rising while SCL is high) releases SDA and abandons a partly received byte without writing it. A transfer that follows a STOP is served normally.
- R3: In a write, the byte after the address loads the register pointer. Each data byte goes to the pointed register and is acknowledged, and the pointer then increments.
- R4: After a pointer write, a repeated START with 0xB1 makes the target send registers MSB first, starting at the pointer and advancing one register per byte while the master acknowledges. After the master answers NACK, SDA is released.
- R5: Synchronous reset loads registers 1 to 7 with C3h, 05h, 0Bh, 00h, 06h, 3Ah and C2h.
- R6: While the shutdown input is low, all seven registers are reloaded with the R5 values.
- R7: Register 1 bit 4 (right fault), bit 3 (left fault) and bit 2 (thermal) are set by their event inputs. Writing 0 clears such a bit. Writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R8: Bits 7:6 of registers 2 to 5 and bits 3:2 of register 7 always read 0. Register 1 bits 7:5 and 1:0, all of register 6, and the remaining bits of registers 2 to 5 and 7 take the written value.
- R9: Address 0 and addresses 8 to 255 hold no storage. Writes to them change no register, and reads from them return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Active-low shutdown; reloads the register defaults |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| evt_fault_r | input | 1 | Right-channel fault event |
| evt_fault_l | input | 1 | Left-channel fault event |
| evt_therm | input | 1 | Over-temperature event |
| cfg_image | output | 56 | Registers 1..7, register n at bits [8n-1:8n-8] |

## Verification
The bench aims at the edges of the pointer range. It reads from register 6 onward into the reserved space, and it writes bursts that run from register 7 into address 8. A design that lets the pointer wrap onto real storage or decodes only the low address bits would corrupt a register there. Sticky flags are set and then written with mixed patterns. A design that uses the usual write-one-to-clear rule would clear the wrong flags, and one that stores plain writes would set flags from software. A STOP in the middle of a data byte and a transfer with a foreign address check two things: a design that commits partial bytes changes register 3, and one that keeps listening after a mismatch drives SDA during a transfer that is not its own. The bench also fires shutdown after several registers have been changed, and a design that skips the reload keeps stale values.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 7;
    localparam int IMG_W    = NUM_REGS * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // register 1 bits that only hardware sets and only a zero write clears
    localparam byte_t STICKY_MASK = 8'h1C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD
    } bus_st_e;

    typedef struct packed {
        logic  start;
        logic  stop;
        logic  rise;
        logic  fall;
        logic  scl;
        logic  sda;
    } line_ev_t;

    typedef struct packed {
        logic  valid;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    function automatic byte_t reg_default(input int idx);
        case (idx)
            1:       return 8'hC3;
            2:       return 8'h05;
            3:       return 8'h0B;
            4:       return 8'h00;
            5:       return 8'h06;
            6:       return 8'h3A;
            7:       return 8'hC2;
            default: return 8'h00;
        endcase
    endfunction

    // plainly writable bits per register (sticky bits handled separately)
    function automatic byte_t reg_wmask(input int idx);
        case (idx)
            1:          return 8'hE3;
            2, 3, 4, 5: return 8'h3F;
            6:          return 8'hFF;
            7:          return 8'hF3;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [IMG_W-1:0] default_image();
        logic [IMG_W-1:0] img;
        img = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            img[i*BYTE_W +: BYTE_W] = reg_default(i + 1);
        end
        return img;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int NLINES = 2;
    localparam int SCL_IX = 1;
    localparam int SDA_IX = 0;

    logic [NLINES-1:0] pin_raw;
    logic [NLINES-1:0] pin_s;
    logic [NLINES-1:0] pin_p;

    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], pin_raw[g]};
        end
        assign pin_s[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) pin_p <= '1;
        else     pin_p <= pin_s;
    end

    always_comb begin
        ev.scl   = pin_s[SCL_IX];
        ev.sda   = pin_s[SDA_IX];
        ev.rise  = pin_s[SCL_IX] & ~pin_p[SCL_IX];
        ev.fall  = ~pin_s[SCL_IX] & pin_p[SCL_IX];
        ev.start = pin_s[SCL_IX] & pin_p[SCL_IX] & pin_p[SDA_IX] & ~pin_s[SDA_IX];
        ev.stop  = pin_s[SCL_IX] & pin_p[SCL_IX] & ~pin_p[SDA_IX] & pin_s[SDA_IX];
    end

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_ctl_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h58
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    input  byte_t    rd_data,
    output wr_req_t  wr,
    output byte_t    ptr,
    output logic     sda_oe
);

    localparam logic [3:0] BIT_LAST = 4'd8;
    localparam logic [3:0] ACK_SLOT = 4'd9;

    bus_st_e    st;
    logic [3:0] cnt;
    byte_t      sh;
    byte_t      tx;
    logic       rw;
    logic       mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (st != ST_IDLE) begin
                if (ev.rise) begin
                    if (cnt < BIT_LAST) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 4'd1;
                    end else if (cnt == ACK_SLOT && st == ST_RD) begin
                        mack <= ~ev.sda;
                    end
                end else if (ev.fall) begin
                    if (cnt == BIT_LAST) begin
                        cnt <= ACK_SLOT;
                        case (st)
                            ST_ADDR: begin
                                if (sh[7:1] == TGT_ADDR) begin
                                    sda_oe <= 1'b1;
                                    rw     <= sh[0];
                                end else begin
                                    st  <= ST_IDLE;
                                    cnt <= '0;
                                end
                            end
                            ST_PTR: begin
                                ptr    <= sh;
                                sda_oe <= 1'b1;
                            end
                            ST_WR: begin
                                wr     <= '{valid: 1'b1, addr: ptr, data: sh};
                                ptr    <= ptr + 8'd1;
                                sda_oe <= 1'b1;
                            end
                            ST_RD: begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 8'd1;
                            end
                            default: ;
                        endcase
                    end else if (cnt == ACK_SLOT) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        case (st)
                            ST_ADDR: begin
                                if (rw) begin
                                    st     <= ST_RD;
                                    tx     <= rd_data;
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                end else begin
                                    st <= ST_PTR;
                                end
                            end
                            ST_PTR: st <= ST_WR;
                            ST_RD: begin
                                if (mack) begin
                                    tx     <= rd_data;
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end else if (st == ST_RD && cnt != 4'd0) begin
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                    end
                end
            end
        end
    end

    // R1: SDA is only ever pulled while SCL is low
    a_r1_pull_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R1: an idle target (mismatch, NACK, STOP) never drives SDA
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R2: STOP releases the line
    a_r2_stop_release: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    // R3: a committed write always advances the pointer
    a_r3_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> (ptr == wr.addr + 8'd1));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn_n,
    input  wr_req_t          wr,
    input  byte_t            rd_addr,
    input  logic [2:0]       evt,
    output byte_t            rd_data,
    output logic [IMG_W-1:0] image
);

    byte_t regs [NUM_REGS];
    byte_t nxt  [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            nxt[i] = regs[i];
            if (wr.valid && wr.addr == byte_t'(i + 1)) begin
                nxt[i] = (regs[i] & ~reg_wmask(i + 1)) | (wr.data & reg_wmask(i + 1));
                if (i == 0) begin
                    nxt[i] = (nxt[i] & ~STICKY_MASK) | (regs[i] & wr.data & STICKY_MASK);
                end
            end
            if (i == 0) begin
                nxt[i] = nxt[i] | {3'b000, evt, 2'b00};
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst || !shdn_n) regs[i] <= reg_default(i + 1);
            else                regs[i] <= nxt[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == byte_t'(i + 1)) rd_data = regs[i];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_img
        assign image[g*BYTE_W +: BYTE_W] = regs[g];
    end

    // R6: shutdown reloads every default
    a_r6_shutdown_reload: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> (image == default_image()));

    // R7: right fault event sets its flag
    a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt[2] && shdn_n) |=> regs[0][4]);

    // R7: writing one to a clear flag does not set it
    a_r7_one_no_set: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.addr == 8'd1 && wr.data[4] && !regs[0][4] && !evt[2] && shdn_n)
        |=> !regs[0][4]);

    // R9: reserved addresses leave the register file untouched
    a_r9_reserved_write: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && (wr.addr == 8'd0 || wr.addr > byte_t'(NUM_REGS)) && shdn_n && evt == 3'b000)
        |=> $stable(image));

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
    import i2c_ctl_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h58,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             evt_fault_r,
    input  logic             evt_fault_l,
    input  logic             evt_therm,
    output logic [IMG_W-1:0] cfg_image
);

    line_ev_t ev;
    wr_req_t  wr;
    byte_t    ptr;
    byte_t    rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_proto_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .wr      (wr),
        .ptr     (ptr),
        .sda_oe  (sda_oe)
    );

    i2c_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .shdn_n  (shdn_n),
        .wr      (wr),
        .rd_addr (ptr),
        .evt     ({evt_fault_r, evt_fault_l, evt_therm}),
        .rd_data (rd_data),
        .image   (cfg_image)
    );

endmodule

// File: tb/i2c_ctl_regs_bench.sv
module i2c_ctl_regs_bench;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shdn_n = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        ev_r = 1'b0, ev_l = 1'b0, ev_t = 1'b0;
    logic [55:0] cfg_image;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit mon_en = 1'b0;
    int mon_hits = 0;
    bit done = 1'b0;

    logic [7:0] exp_r [1:7];

    always #4 clk = ~clk;

    i2c_ctl_regs u_i2c_ctl_regs (
        .clk         (clk),
        .rst         (rst),
        .shdn_n      (shdn_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .evt_fault_r (ev_r),
        .evt_fault_l (ev_l),
        .evt_therm   (ev_t),
        .cfg_image   (cfg_image)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- reference model ----------------
    task automatic model_defaults();
        exp_r[1] = 8'hC3; exp_r[2] = 8'h05; exp_r[3] = 8'h0B; exp_r[4] = 8'h00;
        exp_r[5] = 8'h06; exp_r[6] = 8'h3A; exp_r[7] = 8'hC2;
    endtask

    task automatic model_write(input int p, input logic [7:0] d);
        case (p)
            1: exp_r[1] = {d[7:5], exp_r[1][4:2] & d[4:2], d[1:0]};
            2, 3, 4, 5: exp_r[p] = {2'b00, d[5:0]};
            6: exp_r[6] = d;
            7: exp_r[7] = {d[7:4], 2'b00, d[1:0]};
            default: ;
        endcase
    endtask

    function automatic logic [7:0] model_read(input int p);
        if (p >= 1 && p <= 7) return exp_r[p];
        return 8'h00;
    endfunction

    function automatic logic [55:0] model_image();
        logic [55:0] img;
        for (int i = 1; i <= 7; i++) img[(i-1)*8 +: 8] = exp_r[i];
        return img;
    endfunction

    // every clock: register image against the model
    always @(negedge clk) begin
        if (cmp_en) chk(cfg_image == model_image(), "R3/R7/R8 image vs model", 64'(cfg_image), 64'(model_image()));
        if (mon_en && sda_oe) mon_hits++;
    end

    // ---------------- bus master ----------------
    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input int p, input int n, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        bit ack;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hB0, ack);
        chk(ack, "R1 write address ack", 64'(ack), 64'd1);
        send_byte(8'(p), ack);
        chk(ack, "R3 pointer ack", 64'(ack), 64'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(dv[k], ack);
            chk(ack, "R3 data ack", 64'(ack), 64'd1);
            model_write((p + k) % 256, dv[k]);
        end
        bus_stop();
        tick(4);
        cmp_en = 1'b1;
    endtask

    task automatic rd_txn(input int p, input int n);
        bit ack;
        logic [7:0] b;
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hB0, ack);
        chk(ack, "R1 address ack before read", 64'(ack), 64'd1);
        send_byte(8'(p), ack);
        chk(ack, "R4 pointer ack before read", 64'(ack), 64'd1);
        bus_start();
        send_byte(8'hB1, ack);
        chk(ack, "R1 read address ack", 64'(ack), 64'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == model_read((p + k) % 256), "R4/R9 read data", 64'(b), 64'(model_read((p + k) % 256)));
        end
        tick(Q);
        chk(sda_oe == 1'b0, "R4 line released after NACK", 64'(sda_oe), 64'd0);
        bus_stop();
        tick(4);
        cmp_en = 1'b1;
    endtask

    task automatic pulse_evt(input int which);
        cmp_en = 1'b0;
        case (which)
            0: ev_r = 1'b1;
            1: ev_l = 1'b1;
            default: ev_t = 1'b1;
        endcase
        tick(1);
        ev_r = 1'b0; ev_l = 1'b0; ev_t = 1'b0;
        case (which)
            0: exp_r[1][4] = 1'b1;
            1: exp_r[1][3] = 1'b1;
            default: exp_r[1][2] = 1'b1;
        endcase
        tick(2);
        cmp_en = 1'b1;
    endtask

    initial begin
        bit ack;
        model_defaults();
        tick(5);
        rst = 1'b0;
        tick(2);
        // R5: reset values
        chk(cfg_image == 56'hC23A06000B05C3, "R5 reset image", 64'(cfg_image), 64'h00C23A06000B05C3);
        chk(sda_oe == 1'b0, "R5 SDA released after reset", 64'(sda_oe), 64'd0);
        cmp_en = 1'b1;

        // R3/R8: burst write with masked unused bits
        wr_txn(2, 2, 8'hFF, 8'hFF, 8'h00);
        chk(cfg_image[15:8] == 8'h3F, "R8 reg2 upper bits zero", 64'(cfg_image[15:8]), 64'h3F);
        wr_txn(7, 1, 8'hFF, 8'h00, 8'h00);
        chk(cfg_image[55:48] == 8'hF3, "R8 reg7 bits 3:2 zero", 64'(cfg_image[55:48]), 64'hF3);
        wr_txn(5, 2, 8'hAA, 8'hBB, 8'h00);
        chk(cfg_image[47:40] == 8'hBB, "R3 auto-increment into reg6", 64'(cfg_image[47:40]), 64'hBB);

        // R4: read burst; R9: read running into reserved space
        rd_txn(2, 4);
        rd_txn(6, 3);

        // R9: writes running past reg7 and at address 0
        wr_txn(7, 3, 8'h11, 8'h22, 8'h33);
        wr_txn(0, 1, 8'h44, 8'h00, 8'h00);
        wr_txn(200, 2, 8'h55, 8'h66, 8'h00);

        // R1: foreign address, no acknowledge, line never driven
        cmp_en = 1'b0;
        mon_hits = 0;
        mon_en = 1'b1;
        bus_start();
        send_byte(8'hA0, ack);
        chk(!ack, "R1 foreign address not acknowledged", 64'(ack), 64'd0);
        send_byte(8'h03, ack);
        send_byte(8'h00, ack);
        bus_stop();
        mon_en = 1'b0;
        chk(mon_hits == 0, "R1 SDA untouched after mismatch", 64'(mon_hits), 64'd0);
        tick(4);
        cmp_en = 1'b1;

        // R2: STOP in the middle of a data byte commits nothing
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hB0, ack);
        send_byte(8'h03, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        tick(4);
        chk(sda_oe == 1'b0, "R2 SDA released after STOP", 64'(sda_oe), 64'd0);
        chk(cfg_image[23:16] == exp_r[3], "R2 partial byte not written", 64'(cfg_image[23:16]), 64'(exp_r[3]));
        cmp_en = 1'b1;
        wr_txn(3, 1, 8'h12, 8'h00, 8'h00);
        chk(cfg_image[23:16] == 8'h12, "R2 transfer after STOP served", 64'(cfg_image[23:16]), 64'h12);

        // R7: sticky flags
        pulse_evt(0);
        pulse_evt(1);
        pulse_evt(2);
        chk(cfg_image[7:0] == 8'hDF, "R7 events set flags", 64'(cfg_image[7:0]), 64'hDF);
        wr_txn(1, 1, 8'hFF, 8'h00, 8'h00);
        chk(cfg_image[7:0] == 8'hFF, "R7 writing ones keeps flags", 64'(cfg_image[7:0]), 64'hFF);
        wr_txn(1, 1, 8'hEB, 8'h00, 8'h00);
        chk(cfg_image[7:0] == 8'hEB, "R7 zero clears right and thermal", 64'(cfg_image[7:0]), 64'hEB);
        wr_txn(1, 1, 8'hFF, 8'h00, 8'h00);
        chk(cfg_image[7:0] == 8'hEB, "R7 writing one does not set", 64'(cfg_image[7:0]), 64'hEB);

        // R6: shutdown reload
        cmp_en = 1'b0;
        shdn_n = 1'b0;
        tick(2);
        shdn_n = 1'b1;
        model_defaults();
        tick(2);
        chk(cfg_image == 56'hC23A06000B05C3, "R6 shutdown reload", 64'(cfg_image), 64'h00C23A06000B05C3);
        cmp_en = 1'b1;
        rd_txn(1, 7);

        tick(10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule